// File: doc/BRIEF.md
# Snoop Inquire Cycle Initiator

This block sits on the system side of a processor bus and runs one cache inquire cycle per request. A request carries a 27-bit cache-line address (physical address bits 31 down to 5), an invalidate flag and a choice of how to take the bus: address hold, back-off or full bus hold. The block raises the chosen acquisition output and waits the required delay. It then pulses the inquire strobe for one cycle with the line address and the invalidate flag, and samples the hit and modified-hit responses two cycles later.

A clean or shared response ends the inquire at once. A modified hit means a four-beat writeback follows. The block releases back-off or bus hold so the processor can write the line back, keeps address hold in place, and counts ready beats. It reports completion only when the fourth beat has been seen and modified-hit has dropped. Completion is a one-cycle pulse with the sampled hit and modified-hit status beside it.

Top module: `snoop_inquire_init`

## Requirements
- R1: During and after reset, all bus outputs, `done_o` and both status outputs are low, and `req_ready` is high.
- R2: A request is taken only when `req_ready` is high, which is only in the idle state. While an inquire is in progress `req_ready` is low and `req_valid`/`req_line` changes have no effect on the strobed address.
- R3: `req_method` selects the acquisition output, which rises in the cycle after acceptance: 0 = `addr_hold_o`, 1 = `backoff_o`, 2 = `bus_hold_o`, 3 = treated as 0. At most one acquisition output is high at any time.
- R4: With address hold or back-off, `strobe_o` is high exactly two cycles after the acquisition output first goes high.
- R5: With bus hold, `strobe_o` stays low while `hold_ack_i` is low and goes high in the cycle after `hold_ack_i` is sampled high.
- R6: `strobe_o` is high for one cycle only. `snoop_line_o` carries the request line and `snoop_inv_o` carries the invalidate flag in that same cycle; both are zero at all other times.
- R7: The response lines are sampled in the second cycle after the strobe. If `resp_mod_i` is low there, `done_o` pulses in the next cycle and all acquisition outputs are low in that cycle.
- R8: If `resp_mod_i` is sampled high, `backoff_o` and `bus_hold_o` are low from the next cycle, while `addr_hold_o` stays high until the completion cycle.
- R9: During a writeback, `done_o` follows the fourth `beat_rdy_i` by one cycle when `resp_mod_i` is low on that beat. `beat_rdy_i` seen before the writeback state is not counted.
- R10: If `resp_mod_i` is still high after the fourth beat, completion waits and `done_o` rises in the cycle after `resp_mod_i` is sampled low.
- R11: `done_o` is a one-cycle pulse. `done_hit_o` and `done_mod_o` show the sampled hit and modified-hit values only while `done_o` is high, and `req_ready` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Inquire request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_line | input | 27 | Cache-line address of the request |
| req_inv | input | 1 | Invalidate the line on a hit |
| req_method | input | 2 | Bus acquisition method |
| addr_hold_o | output | 1 | Address hold to the processor |
| backoff_o | output | 1 | Back-off to the processor |
| bus_hold_o | output | 1 | Bus hold request to the processor |
| hold_ack_i | input | 1 | Hold acknowledge from the processor |
| strobe_o | output | 1 | External address strobe for the inquire |
| snoop_inv_o | output | 1 | Invalidate flag driven with the strobe |
| snoop_line_o | output | 27 | Line address driven with the strobe |
| resp_hit_i | input | 1 | Hit response |
| resp_mod_i | input | 1 | Modified-hit response |
| beat_rdy_i | input | 1 | Ready for one writeback transfer |
| done_o | output | 1 | Inquire complete pulse |
| done_hit_o | output | 1 | Sampled hit, valid with done |
| done_mod_o | output | 1 | Sampled modified-hit, valid with done |

## Verification
The hardest case to reach is a modified hit taken by back-off, where `resp_mod_i` stays high after the fourth ready beat while the requester keeps a different request on the input. In that case three rules have to hold together: early release of back-off, beat counting that ignores a stray ready in the response window, and held-back completion. The stimulus gets there by keeping `req_valid` high with a changed line for the whole inquire and raising `beat_rdy_i` in the sampling cycle. It then spaces the four beats with idle cycles and keeps `resp_mod_i` high for extra cycles after them. A bus-hold case with a slow acknowledge and a reserved method code cover the remaining acquisition timing.

// File: rtl/snp_pkg.sv
// Package: shared types for the snoop inquire initiator.
// Assumes: method codes match the requirement encoding (0,1,2; 3 reserved).
package snp_pkg;
    typedef enum logic [1:0] {
        ACQ_ADDR_HOLD = 2'd0,
        ACQ_BACKOFF   = 2'd1,
        ACQ_BUS_HOLD  = 2'd2,
        ACQ_RESERVED  = 2'd3
    } acq_method_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_STROBE,
        ST_RESP,
        ST_WB,
        ST_DRAIN,
        ST_DONE
    } snp_state_e;
endpackage

// File: rtl/snp_step_counter.sv
// Module: snp_step_counter
// Counts enabled cycles and clears on request; clear wins over increment.
// Assumes: the owner ignores the value once it has passed the limit it compares against.
module snp_step_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/snp_req_latch.sv
// Module: snp_req_latch
// Holds the accepted request for the whole inquire and maps the reserved method code onto address hold.
// Assumes: load is high only for one cycle, in the cycle the request is accepted.
module snp_req_latch
    import snp_pkg::*;
#(
    parameter int ADDR_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] line_in,
    input  logic              inv_in,
    input  logic [1:0]        method_in,
    output logic [ADDR_W-1:0] line_q,
    output logic              inv_q,
    output acq_method_e       method_q
);
    acq_method_e method_norm;

    // Map the reserved code onto the address-hold method.
    always_comb begin
        method_norm = acq_method_e'(method_in);
        if (method_norm == ACQ_RESERVED) method_norm = ACQ_ADDR_HOLD;
    end

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= '0;
            inv_q    <= 1'b0;
            method_q <= ACQ_ADDR_HOLD;
        end else if (load) begin
            line_q   <= line_in;
            inv_q    <= inv_in;
            method_q <= method_norm;
        end
    end
endmodule

// File: rtl/snoop_inquire_init.sv
// Module: snoop_inquire_init
// Runs one inquire cycle per request: takes the bus by the chosen method, strobes the line address,
// samples the hit responses, follows a modified-hit writeback and pulses done with status.
// Assumes: the processor drives single-cycle ready beats and raises hold acknowledge only while bus hold is high.
module snoop_inquire_init
    import snp_pkg::*;
#(
    parameter int ADDR_W     = 27,
    parameter int STROBE_DLY = 2,
    parameter int RESP_DLY   = 2,
    parameter int BURST_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_line,
    input  logic              req_inv,
    input  logic [1:0]        req_method,
    output logic              addr_hold_o,
    output logic              backoff_o,
    output logic              bus_hold_o,
    input  logic              hold_ack_i,
    output logic              strobe_o,
    output logic              snoop_inv_o,
    output logic [ADDR_W-1:0] snoop_line_o,
    input  logic              resp_hit_i,
    input  logic              resp_mod_i,
    input  logic              beat_rdy_i,
    output logic              done_o,
    output logic              done_hit_o,
    output logic              done_mod_o
);
    localparam int DLY_MAX = (STROBE_DLY > RESP_DLY) ? STROBE_DLY : RESP_DLY;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int BEAT_W  = $clog2(BURST_LEN + 1);
    localparam logic [DLY_W-1:0]  STROBE_LAST = DLY_W'(STROBE_DLY - 1);
    localparam logic [DLY_W-1:0]  RESP_LAST   = DLY_W'(RESP_DLY - 1);
    localparam logic [BEAT_W-1:0] BEAT_LAST   = BEAT_W'(BURST_LEN - 1);

    snp_state_e        state, nxt;
    acq_method_e       method_q;
    logic [ADDR_W-1:0] line_q;
    logic              inv_q;
    logic [DLY_W-1:0]  dly_cnt;
    logic [BEAT_W-1:0] beat_cnt;
    logic              hit_q, mod_q;
    logic              accept, resp_sample, last_beat, bus_held;

    assign accept      = (state == ST_IDLE) && req_valid;
    assign resp_sample = (state == ST_RESP) && (dly_cnt == RESP_LAST);
    assign last_beat   = (state == ST_WB) && beat_rdy_i && (beat_cnt == BEAT_LAST);

    snp_req_latch #(.ADDR_W(ADDR_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .line_in   (req_line),
        .inv_in    (req_inv),
        .method_in (req_method),
        .line_q    (line_q),
        .inv_q     (inv_q),
        .method_q  (method_q)
    );

    snp_step_counter #(.CNT_W(DLY_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != nxt),
        .inc   (1'b1),
        .count (dly_cnt)
    );

    snp_step_counter #(.CNT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_WB),
        .inc   ((state == ST_WB) && beat_rdy_i),
        .count (beat_cnt)
    );

    // Next-state decision for the inquire sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_ACQ;
            ST_ACQ: begin
                if (method_q == ACQ_BUS_HOLD) begin
                    if (hold_ack_i) nxt = ST_STROBE;
                end else if (dly_cnt == STROBE_LAST) begin
                    nxt = ST_STROBE;
                end
            end
            ST_STROBE: nxt = ST_RESP;
            ST_RESP:   if (resp_sample) nxt = resp_mod_i ? ST_WB : ST_DONE;
            ST_WB:     if (last_beat) nxt = resp_mod_i ? ST_DRAIN : ST_DONE;
            ST_DRAIN:  if (!resp_mod_i) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Capture the response lines at the sampling point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            mod_q <= 1'b0;
        end else if (resp_sample) begin
            hit_q <= resp_hit_i;
            mod_q <= resp_mod_i;
        end
    end

    // Decode the bus-side and requester-side outputs from the state.
    always_comb begin
        bus_held     = (state == ST_ACQ) || (state == ST_STROBE) || (state == ST_RESP);
        addr_hold_o  = (method_q == ACQ_ADDR_HOLD) &&
                       (bus_held || (state == ST_WB) || (state == ST_DRAIN));
        backoff_o    = (method_q == ACQ_BACKOFF)  && bus_held;
        bus_hold_o   = (method_q == ACQ_BUS_HOLD) && bus_held;
        strobe_o     = (state == ST_STROBE);
        snoop_inv_o  = strobe_o && inv_q;
        snoop_line_o = strobe_o ? line_q : '0;
        req_ready    = (state == ST_IDLE);
        done_o       = (state == ST_DONE);
        done_hit_o   = done_o && hit_q;
        done_mod_o   = done_o && mod_q;
    end
endmodule

// File: rtl/snp_inquire_checker.sv
// Module: snp_inquire_checker
// Port-level protocol properties for snoop_inquire_init, attached by bind.
// Assumes: reset is synchronous and active low.
module snp_inquire_checker #(
    parameter int ADDR_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              addr_hold_o,
    input logic              backoff_o,
    input logic              bus_hold_o,
    input logic              hold_ack_i,
    input logic              strobe_o,
    input logic              snoop_inv_o,
    input logic [ADDR_W-1:0] snoop_line_o,
    input logic              done_o,
    input logic              done_hit_o,
    input logic              done_mod_o
);
    a_r3_one_method: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_hold_o, backoff_o, bus_hold_o}));

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hold_o || backoff_o || bus_hold_o || done_o) |-> !req_ready);

    a_r4_ahold_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hold_o) |-> ##2 strobe_o);

    a_r4_boff_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(backoff_o) |-> ##2 strobe_o);

    a_r5_hold_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && bus_hold_o) |-> $past(hold_ack_i));

    a_r6_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    a_r6_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> (snoop_line_o == '0 && !snoop_inv_o));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_status_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (done_hit_o || done_mod_o) |-> done_o);
endmodule

bind snoop_inquire_init snp_inquire_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/snoop_inquire_init_test.sv
// Bench: directed scenarios for snoop_inquire_init, one task each, checked cycle by cycle.
module snoop_inquire_init_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_inv = 1'b0;
    logic [26:0] req_line = '0;
    logic [1:0]  req_method = 2'd0;
    logic        addr_hold_o, backoff_o, bus_hold_o, hold_ack_i = 1'b0;
    logic        strobe_o, snoop_inv_o;
    logic [26:0] snoop_line_o;
    logic        resp_hit_i = 1'b0, resp_mod_i = 1'b0, beat_rdy_i = 1'b0;
    logic        done_o, done_hit_o, done_mod_o;
    int          errors = 0, checks = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    snoop_inquire_init uut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk(!addr_hold_o && !backoff_o && !bus_hold_o, "R1 acquisition low in reset",
            {addr_hold_o, backoff_o, bus_hold_o}, 0);
        chk(!strobe_o && snoop_line_o == 0 && !snoop_inv_o, "R1 strobe quiet in reset", strobe_o, 0);
        rst_n = 1'b1;
        tick();
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        chk(!done_o && !done_hit_o && !done_mod_o, "R1 done low after reset",
            {done_o, done_hit_o, done_mod_o}, 0);
    endtask

    // One full inquire, checked at every step against the requirements.
    task automatic run_snoop(input int method, input logic [26:0] line, input bit inv,
                             input bit hit, input bit hitm, input int ack_wait,
                             input int drain_extra, input bit poke_busy);
        bit ea, eb, eh;
        ea = (method == 0) || (method == 3);
        eb = (method == 1);
        eh = (method == 2);
        req_valid = 1'b1; req_line = line; req_inv = inv; req_method = 2'(method);
        tick();
        req_valid = poke_busy;
        if (poke_busy) begin req_line = ~line; req_inv = ~inv; end
        chk(!req_ready, "R2 not ready while busy", req_ready, 0);
        chk(addr_hold_o == ea && backoff_o == eb && bus_hold_o == eh, "R3 acquisition output",
            {addr_hold_o, backoff_o, bus_hold_o}, {ea, eb, eh});
        chk(!strobe_o, "R4 no strobe in first held cycle", strobe_o, 0);
        if (eh) begin
            for (int i = 0; i < ack_wait; i++) begin
                tick();
                chk(!strobe_o, "R5 no strobe before hold ack", strobe_o, 0);
            end
            hold_ack_i = 1'b1;
            tick();
            hold_ack_i = 1'b0;
            chk(strobe_o, "R5 strobe one cycle after hold ack", strobe_o, 1);
        end else begin
            tick();
            chk(!strobe_o, "R4 no strobe in second held cycle", strobe_o, 0);
            tick();
            chk(strobe_o, "R4 strobe two cycles after acquisition", strobe_o, 1);
        end
        chk(snoop_line_o == line, "R6 line with strobe (R2 busy request ignored)", snoop_line_o, line);
        chk(snoop_inv_o == inv, "R6 invalidate with strobe", snoop_inv_o, inv);
        tick();
        chk(!strobe_o && snoop_line_o == 0, "R6 strobe single cycle", strobe_o, 0);
        tick();
        resp_hit_i = hit; resp_mod_i = hitm; beat_rdy_i = poke_busy;
        tick();
        resp_hit_i = 1'b0; beat_rdy_i = 1'b0;
        if (!hitm) begin
            chk(done_o, "R7 done after clean response", done_o, 1);
            chk(done_hit_o == hit && !done_mod_o, "R11 status on done", {done_hit_o, done_mod_o}, {hit, 1'b0});
            chk(!addr_hold_o && !backoff_o && !bus_hold_o, "R7 bus released on done",
                {addr_hold_o, backoff_o, bus_hold_o}, 0);
        end else begin
            chk(!done_o, "R8 no done on modified hit", done_o, 0);
            chk(!backoff_o && !bus_hold_o && addr_hold_o == ea, "R8 release for writeback",
                {addr_hold_o, backoff_o, bus_hold_o}, {ea, 2'b00});
            for (int b = 0; b < 4; b++) begin
                tick();
                chk(!done_o, "R9 no done mid writeback", done_o, 0);
                beat_rdy_i = 1'b1;
                if (b == 3 && drain_extra == 0) resp_mod_i = 1'b0;
                tick();
                beat_rdy_i = 1'b0;
                if (b < 3) chk(!done_o, "R9 no done before fourth beat", done_o, 0);
            end
            if (drain_extra > 0) begin
                for (int i = 0; i < drain_extra; i++) begin
                    chk(!done_o && addr_hold_o == ea, "R10 done held while modified-hit high",
                        {done_o, addr_hold_o}, {1'b0, ea});
                    tick();
                end
                resp_mod_i = 1'b0;
                tick();
            end
            chk(done_o, "R9 done after writeback", done_o, 1);
            chk(done_mod_o && done_hit_o == hit, "R11 modified status on done",
                {done_hit_o, done_mod_o}, {hit, 1'b1});
            chk(!addr_hold_o, "R8 address hold released on done", addr_hold_o, 0);
        end
        req_valid = 1'b0;
        tick();
        chk(!done_o && req_ready, "R11 done single cycle, ready again", {done_o, req_ready}, 2'b01);
        tick();
    endtask

    initial begin
        check_reset();
        run_snoop(0, 27'h12_3456, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
        run_snoop(1, 27'h7AB_CDEF, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0);
        run_snoop(2, 27'h055_5555, 1'b1, 1'b1, 1'b0, 3, 0, 1'b0);
        run_snoop(0, 27'h2AA_AAAA, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0);
        run_snoop(1, 27'h000_0F0F, 1'b0, 1'b1, 1'b1, 0, 2, 1'b1);
        run_snoop(2, 27'h7FF_FFFF, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0);
        run_snoop(3, 27'h101_0101, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule